// File: doc/BRIEF.md
# Index-Register Effective Address Unit

This unit turns the mode and address fields of a memory-reference instruction into an operand address. It owns the machine's index register and applies that register's automatic update in the same step as the address calculation. It supports four modes:

- **direct**: the address field as it is.
- **indexed**: the address field plus the register.
- **post-increment**: the address field plus the old register value, after which the register goes up by one.
- **pre-decrement**: the register first goes down by one, and the address is the field plus the new value.

Each result carries two forms of the address. The low bits form the memory address, and any higher bits are dropped silently. The whole unmasked sum is also given, so that a load-literal instruction can take it as its value.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On that edge the result is registered and the index register is updated, so each accepted request applies its update exactly once. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result is held unchanged and no request is accepted.

A separate plain load port writes the index register directly, for load-index and subroutine-call instructions. On a shared edge it wins over an automatic update.

Top module: `ea_unit`

## Requirements
- R1: After reset the index register `xr_q` reads 0 and `res_valid` is low.
- R2: Mode code 0 (direct) produces a sum equal to the zero-extended address field, and the index register is not changed.
- R3: Mode code 1 (indexed) produces the address field plus the index register, and the index register is not changed.
- R4: Mode code 2 (post-increment) produces the address field plus the register value held before the request, and the register then holds that value plus one.
- R5: Mode code 3 (pre-decrement) sets the register to its old value minus one and produces the address field plus that new value.
- R6: `res_mem_addr` equals the low ADR_W bits of `res_sum`. Higher bits of the sum are dropped with no error indication.
- R7: The index register changes only on an accepted request or on a load. A request offered while `req_ready` is low has no effect on the register.
- R8: When `xr_load_en` is high, the register takes `xr_load_data` on that edge, even if an accepted request would have incremented or decremented it.
- R9: All register arithmetic and the sum wrap modulo 2^XR_W. Decrementing 0 gives all ones, and incrementing all ones gives 0.
- R10: While `res_valid` is high and `res_ready` is low, `req_ready` is low and `res_valid`, `res_sum` and `res_mem_addr` stay stable. An accepted request produces `res_valid` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 2 | Mode code: 0 direct, 1 indexed, 2 post-increment, 3 pre-decrement |
| req_adr | input | ADR_W | Address field of the instruction |
| xr_load_en | input | 1 | Write the index register this cycle |
| xr_load_data | input | XR_W | Value for the index register write |
| res_valid | output | 1 | Result held in the output register |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_mem_addr | output | ADR_W | Low bits of the sum, for memory |
| res_sum | output | XR_W | Full unmasked sum, for literal loads |
| xr_q | output | XR_W | Current index register value |

## Verification
Each mode is driven on its own with directed index values. Indexed and direct requests are run against a non-zero register, which separates "add the register" from "ignore it". Post-increment and pre-decrement requests are run back to back, which shows whether the sum uses the old or the new register value. Register values of 0 and all ones, with large address fields, expose carries lost above the memory width and wrap-around of the register. A stalled output with a request held at the input shows whether the register update is gated by acceptance. A load issued together with a post-increment request shows which write wins. A long random mix of modes, loads and stalls, checked against a bench model, covers the combinations between these cases.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    EA_DIRECT  = 2'd0,
    EA_INDEXED = 2'd1,
    EA_POSTINC = 2'd2,
    EA_PREDEC  = 2'd3
  } ea_mode_e;
endpackage

// File: rtl/ea_calc.sv
// Combinational address sum and proposed index register update.
module ea_calc
  import ea_pkg::*;
#(
  parameter int XR_W  = 32,
  parameter int ADR_W = 10
) (
  input  ea_mode_e          mode,
  input  logic [ADR_W-1:0]  adr,
  input  logic [XR_W-1:0]   xr,
  output logic [XR_W-1:0]   sum,
  output logic [XR_W-1:0]   xr_next,
  output logic              xr_touch
);
  localparam int PAD_W = XR_W - ADR_W;

  logic [XR_W-1:0] adr_ext;
  logic [XR_W-1:0] xr_inc;
  logic [XR_W-1:0] xr_dec;
  logic [XR_W-1:0] offset;

  generate
    if (PAD_W > 0) begin : g_pad
      assign adr_ext = {{PAD_W{1'b0}}, adr};
    end else begin : g_nopad
      assign adr_ext = adr[XR_W-1:0];
    end
  endgenerate

  assign xr_inc = xr + {{(XR_W-1){1'b0}}, 1'b1};
  assign xr_dec = xr - {{(XR_W-1){1'b0}}, 1'b1};

  always_comb begin
    offset   = xr;
    xr_next  = xr;
    xr_touch = 1'b0;
    unique case (mode)
      EA_DIRECT:  offset = '0;
      EA_INDEXED: offset = xr;
      EA_POSTINC: begin
        offset   = xr;
        xr_next  = xr_inc;
        xr_touch = 1'b1;
      end
      EA_PREDEC: begin
        offset   = xr_dec;
        xr_next  = xr_dec;
        xr_touch = 1'b1;
      end
      default: offset = '0;
    endcase
  end

  assign sum = adr_ext + offset;
endmodule

// File: rtl/ea_xr_reg.sv
// Index register with a direct load that overrides the automatic update.
module ea_xr_reg #(
  parameter int XR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [XR_W-1:0] load_data,
  input  logic            upd_en,
  input  logic [XR_W-1:0] upd_data,
  output logic [XR_W-1:0] xr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       xr_q <= '0;
    else if (load_en) xr_q <= load_data;
    else if (upd_en)  xr_q <= upd_data;
  end

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> xr_q == $past(load_data));

  // R7
  xr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !upd_en) |=> $stable(xr_q));
endmodule

// File: rtl/ea_out_stage.sv
// Single output register with valid/ready hand-off.
module ea_out_stage #(
  parameter int XR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XR_W-1:0] in_sum,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XR_W-1:0] out_sum
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      if (take)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (take)           out_sum   <= in_sum;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int XR_W  = 32,
  parameter int ADR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_mode,
  input  logic [ADR_W-1:0] req_adr,
  input  logic             xr_load_en,
  input  logic [XR_W-1:0]  xr_load_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ADR_W-1:0] res_mem_addr,
  output logic [XR_W-1:0]  res_sum,
  output logic [XR_W-1:0]  xr_q
);
  logic [XR_W-1:0] calc_sum;
  logic [XR_W-1:0] calc_xr;
  logic            calc_touch;
  logic            fire;
  ea_mode_e        mode_e;

  assign mode_e = ea_mode_e'(req_mode);
  assign fire   = req_valid && req_ready;

  ea_calc #(.XR_W(XR_W), .ADR_W(ADR_W)) u_calc (
    .mode     (mode_e),
    .adr      (req_adr),
    .xr       (xr_q),
    .sum      (calc_sum),
    .xr_next  (calc_xr),
    .xr_touch (calc_touch)
  );

  ea_xr_reg #(.XR_W(XR_W)) u_xr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (xr_load_en),
    .load_data (xr_load_data),
    .upd_en    (fire && calc_touch),
    .upd_data  (calc_xr),
    .xr_q      (xr_q)
  );

  ea_out_stage #(.XR_W(XR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_sum    (calc_sum),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_sum   (res_sum)
  );

  assign res_mem_addr = res_sum[ADR_W-1:0];

  // R2
  direct_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_mode == 2'd0) |=> res_sum == XR_W'($past(req_adr)));

  // R4
  postinc_xr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_mode == 2'd2 && !xr_load_en) |=> xr_q == $past(xr_q) + 1);

  // R5
  predec_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_mode == 2'd3 && !xr_load_en) |=> res_sum == XR_W'(req_adr) + xr_q
      || !$stable(req_adr));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  localparam int XR_W = 32;
  localparam int ADR_W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_mode = 2'd0;
  logic [ADR_W-1:0] req_adr = '0;
  logic xr_load_en = 1'b0;
  logic [XR_W-1:0] xr_load_data = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [ADR_W-1:0] res_mem_addr;
  logic [XR_W-1:0] res_sum;
  logic [XR_W-1:0] xr_q;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [XR_W-1:0] xr_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_unit #(.XR_W(XR_W), .ADR_W(ADR_W)) u_ea_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_adr(req_adr), .xr_load_en(xr_load_en),
    .xr_load_data(xr_load_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_mem_addr(res_mem_addr), .res_sum(res_sum), .xr_q(xr_q)
  );

  function automatic logic [XR_W-1:0] m_sum(input logic [1:0] md,
      input logic [ADR_W-1:0] a, input logic [XR_W-1:0] x);
    case (md)
      2'd0: return XR_W'(a);
      2'd1: return XR_W'(a) + x;
      2'd2: return XR_W'(a) + x;
      default: return XR_W'(a) + (x - 1);
    endcase
  endfunction

  function automatic logic [XR_W-1:0] m_xr(input logic [1:0] md,
      input logic [XR_W-1:0] x);
    case (md)
      2'd2: return x + 1;
      2'd3: return x - 1;
      default: return x;
    endcase
  endfunction

  task automatic chk(input string req, input logic [XR_W-1:0] act,
      input logic [XR_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One accepted request with the output drained; optional load in same cycle.
  task automatic one_req(input string req, input logic [1:0] md,
      input logic [ADR_W-1:0] a, input bit ld, input logic [XR_W-1:0] ld_val);
    logic [XR_W-1:0] es;
    logic [XR_W-1:0] ex;
    @(negedge clk);
    res_ready = 1'b1;
    req_valid = 1'b1;
    req_mode = md;
    req_adr = a;
    xr_load_en = ld;
    xr_load_data = ld_val;
    es = m_sum(md, a, xr_m);
    ex = ld ? ld_val : m_xr(md, xr_m);
    @(negedge clk);
    req_valid = 1'b0;
    xr_load_en = 1'b0;
    xr_m = ex;
    chk({req, " valid"}, XR_W'(res_valid), 1);
    chk({req, " sum"}, res_sum, es);
    chk({req, " xr"}, xr_q, ex);
    // R6 low bits of sum go to memory
    chk("R6 mem_addr", XR_W'(res_mem_addr), XR_W'(es[ADR_W-1:0]));
  endtask

  task automatic load_xr(input logic [XR_W-1:0] v);
    @(negedge clk);
    xr_load_en = 1'b1;
    xr_load_data = v;
    @(negedge clk);
    xr_load_en = 1'b0;
    xr_m = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [XR_W-1:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 xr", xr_q, 0);
    chk("R1 valid", XR_W'(res_valid), 0);
    rst_n = 1'b1;

    load_xr(32'h0000_0123);
    one_req("R2 direct", 2'd0, 10'h3A5, 0, 0);
    one_req("R3 indexed", 2'd1, 10'h010, 0, 0);
    one_req("R4 postinc", 2'd2, 10'h200, 0, 0);
    one_req("R4 postinc", 2'd2, 10'h200, 0, 0);
    one_req("R5 predec", 2'd3, 10'h001, 0, 0);
    one_req("R5 predec", 2'd3, 10'h001, 0, 0);
    // R9 wrap at both ends, R6 high bits dropped
    load_xr(32'h0);
    one_req("R9 predec wrap", 2'd3, 10'h3FF, 0, 0);
    one_req("R9 postinc wrap", 2'd2, 10'h3FF, 0, 0);
    load_xr(32'h0000_03FF);
    one_req("R6 carry", 2'd1, 10'h3FF, 0, 0);
    // R8 load beats auto-increment
    one_req("R8 load wins", 2'd2, 10'h005, 1, 32'hDEAD_BEEF);

    // R7 / R10 stall: output held, request refused, xr untouched
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1;
    req_mode = 2'd1;
    req_adr = 10'h00F;
    held = m_sum(2'd1, 10'h00F, xr_m);
    @(negedge clk);
    req_mode = 2'd2;
    req_adr = 10'h020;
    chk("R10 ready low", XR_W'(req_ready), 0);
    repeat (2) @(negedge clk);
    chk("R10 valid held", XR_W'(res_valid), 1);
    chk("R10 sum held", res_sum, held);
    chk("R7 xr stalled", xr_q, xr_m);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 accepted after stall", xr_q, xr_m + 1);
    chk("R10 new sum", res_sum, m_sum(2'd2, 10'h020, xr_m));
    xr_m = xr_m + 1;
    @(negedge clk);
    chk("R10 drained", XR_W'(res_valid), 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      logic [ADR_W-1:0] a;
      bit ld;
      md = 2'($urandom);
      a = ADR_W'($urandom);
      ld = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) load_xr((($urandom % 2) == 0) ? 32'hFFFF_FFFE : $urandom);
      case (md)
        2'd0: one_req("R2 rand", md, a, ld, $urandom);
        2'd1: one_req("R3 rand", md, a, ld, $urandom);
        2'd2: one_req("R4 rand", md, a, ld, $urandom);
        default: one_req("R5 rand", md, a, ld, $urandom);
      endcase
    end
    finish_run();
  end
endmodule